// File: doc/BRIEF.md
# Three-Wire Front-End Configuration Port

This block is the slave side of a serial configuration link for a four-channel imaging front end. An external controller pulls an active-low framing strobe low. It then clocks a 14-bit frame over a serial clock: a direction flag, a 4-bit register address and a 9-bit data word, most significant bit first. The block keeps the register file that steers the datapath. That file holds one configuration register, one channel-multiplexer register, a gain register for each of the four channels and an offset register for each of the four channels. The configuration and multiplexer fields are decoded onto individual control outputs. The gain and offset contents are exported as raw words.

The serial pins are asynchronous to the block's system clock. They are resynchronised, and their edges are found by oversampling, so the serial clock must run several times slower than the system clock. A write frame takes effect only when the strobe rises after exactly 14 serial-clock rising edges. A read frame turns the data line around after the header. The addressed register is then shifted out one bit per serial-clock falling edge. The shared data pin appears as a separate input, output and output enable, and the pad is built outside the block.

The frame controller has five states. ST_IDLE means no frame is open; a falling strobe moves to ST_HEAD. ST_HEAD collects the flag and the address; the fifth rising edge moves to ST_BODY. ST_BODY collects or returns the data word; the fourteenth rising edge moves to ST_DONE. ST_DONE means the frame length is exact; a further rising edge moves to ST_SPILL, which marks an overlong frame. From any state a rising strobe returns to ST_IDLE. Only the exit from ST_DONE of a write frame commits.

Top module: `afe_serial_regs`

## Requirements
- R1: A frame is sent MSB first: the direction bit (1 = read, 0 = write), then address bits 3..0, then data bits 8..0. Input bits are taken on serial-clock rising edges.
- R2: A write is committed only if the strobe rises after exactly 14 rising edges. A frame of 13 or 15 edges leaves every register unchanged.
- R3: The address map is: 0 configuration, 1 multiplexer, 2..5 gain of channels A..D, 6..9 offset of channels A..D. Channel A's gain occupies gain_o[5:0] and its offset occupies offset_o[8:0], and channels B..D follow upward.
- R4: Reserved bits are stored as zero. These are configuration bits 8..6, multiplexer bits 8..5 and gain bits 8..6. Offset registers keep all nine bits.
- R5: Writes to addresses 10..15 change nothing, and reads of those addresses return zero.
- R6: On a read, sdo_oe rises with the fifth rising edge. Data bit 8 is driven after the next falling edge, and each later falling edge presents the next lower bit. sdo_oe is low outside that window.
- R7: After reset every register is zero. The block therefore starts asleep, with two-byte output, correlated double sampling, the low input range and the fast setting.
- R8: Configuration decode: bit 5 external reference, bit 4 single-byte output, bit 3 sample-and-hold mode, bit 2 wide input range, bit 1 slow low-power mode, bit 0 power on.
- R9: Multiplexer decode: bit 4 reverses the channel order. mux_chan_en[3..0] mirrors bits 3..0, with bit 3 selecting channel A and bit 0 selecting channel D.
- R10: Clearing the power bit keeps all other register contents.
- R11: A read frame never modifies a register, whatever its data bits carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock |
| frame_n | input | 1 | Active-low frame strobe |
| sdi | input | 1 | Serial data from the controller |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Enable for the shared data pad |
| cfg_ext_ref | output | 1 | External reference selected |
| cfg_one_byte | output | 1 | Single-byte output mode |
| cfg_sha_mode | output | 1 | Sample-and-hold mode (0 = CDS) |
| cfg_wide_range | output | 1 | Wide input range |
| cfg_slow | output | 1 | Slow low-power mode |
| cfg_power_on | output | 1 | Device awake |
| mux_reverse | output | 1 | Reversed channel order |
| mux_chan_en | output | 4 | Single-channel selects, bit 3 = A |
| gain_o | output | 24 | Gain words, six bits per channel |
| offset_o | output | 36 | Offset words, nine bits per channel |

## Verification
The assertions check four things on every cycle. A commit never follows a frame whose edge count differs from fourteen or a frame that drove read data. The output enable lives only in the data phase. Reserved bits stay zero, a write to an unmapped address leaves the file untouched, and the file stays zero until the first commit. The bench scenarios are needed to show bit order and the address-to-field mapping at the decoded outputs. They also show read-back timing seen from the pin, rejection of short and long frames, retention across a sleep write, and that a read carrying nonzero data leaves contents intact.

// File: rtl/afe_ser_pkg.sv
package afe_ser_pkg;
    localparam int DATA_W    = 9;
    localparam int ADDR_W    = 4;
    localparam int HDR_LEN   = 1 + ADDR_W;
    localparam int FRAME_LEN = HDR_LEN + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 2);
    localparam int NUM_CH    = 4;
    localparam int GAIN_W    = 6;
    localparam int OFS_W     = DATA_W;

    localparam int ADDR_CFG  = 0;
    localparam int ADDR_MUX  = 1;
    localparam int GAIN_BASE = 2;
    localparam int OFS_BASE  = GAIN_BASE + NUM_CH;
    localparam int LAST_ADDR = OFS_BASE + NUM_CH - 1;

    localparam logic [DATA_W-1:0] CFG_KEEP  = DATA_W'(9'h03F);
    localparam logic [DATA_W-1:0] MUX_KEEP  = DATA_W'(9'h01F);
    localparam logic [DATA_W-1:0] GAIN_KEEP = DATA_W'((1 << GAIN_W) - 1);
    localparam logic [DATA_W-1:0] OFS_KEEP  = {DATA_W{1'b1}};

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_BODY,
        ST_DONE,
        ST_SPILL
    } frame_state_t;
endpackage

// File: rtl/afe_sync.sv
module afe_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/afe_frame_fsm.sv
module afe_frame_fsm
    import afe_ser_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sclk_s,
    input  logic  frame_n_s,
    input  logic  sdi_s,
    input  word_t rd_word,
    output addr_t rd_addr,
    output logic  wr_en,
    output addr_t wr_addr,
    output word_t wr_data,
    output logic  sdo,
    output logic  sdo_oe
);
    localparam logic [CNT_W-1:0] CNT_HDR_LAST = CNT_W'(HDR_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_FRM_LAST = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_EXACT    = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] CNT_SAT      = {CNT_W{1'b1}};

    frame_state_t state, state_nx;
    logic sclk_d, frame_d;
    logic sclk_rise, sclk_fall, frm_start, frm_end;
    logic [FRAME_LEN-1:0] sr;
    logic [HDR_LEN-1:0]   hdr_next;
    logic [CNT_W-1:0]     cnt;
    word_t                rd_sr;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign frm_start = ~frame_n_s & frame_d;
    assign frm_end   = frame_n_s & ~frame_d;
    assign hdr_next  = {sr[HDR_LEN-2:0], sdi_s};
    assign rd_addr   = hdr_next[ADDR_W-1:0];
    assign wr_addr   = sr[FRAME_LEN-2 -: ADDR_W];
    assign wr_data   = sr[DATA_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sclk_d  <= 1'b0;
            frame_d <= 1'b1;
        end else begin
            state   <= state_nx;
            sclk_d  <= sclk_s;
            frame_d <= frame_n_s;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (frm_start) state_nx = ST_HEAD;
            ST_HEAD:  if (frm_end) state_nx = ST_IDLE;
                      else if (sclk_rise && cnt == CNT_HDR_LAST) state_nx = ST_BODY;
            ST_BODY:  if (frm_end) state_nx = ST_IDLE;
                      else if (sclk_rise && cnt == CNT_FRM_LAST) state_nx = ST_DONE;
            ST_DONE:  if (frm_end) state_nx = ST_IDLE;
                      else if (sclk_rise) state_nx = ST_SPILL;
            ST_SPILL: if (frm_end) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr     <= '0;
            cnt    <= '0;
            rd_sr  <= '0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
            wr_en  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (frm_start) begin
                cnt    <= '0;
                sdo_oe <= 1'b0;
            end
            if (sclk_rise && state != ST_IDLE && cnt != CNT_SAT)
                cnt <= cnt + 1'b1;
            if (sclk_rise && (state == ST_HEAD || state == ST_BODY))
                sr <= {sr[FRAME_LEN-2:0], sdi_s};
            if (sclk_rise && state == ST_HEAD && cnt == CNT_HDR_LAST && hdr_next[HDR_LEN-1]) begin
                rd_sr  <= rd_word;
                sdo_oe <= 1'b1;
            end
            if (sclk_fall && state == ST_BODY && sdo_oe) begin
                sdo   <= rd_sr[DATA_W-1];
                rd_sr <= {rd_sr[DATA_W-2:0], 1'b0};
            end
            if (frm_end) begin
                sdo_oe <= 1'b0;
                if (state == ST_DONE && !sr[FRAME_LEN-1]) wr_en <= 1'b1;
            end
        end
    end

    assert_commit_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> cnt == CNT_EXACT);

    assert_oe_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (state == ST_BODY || state == ST_DONE || state == ST_SPILL));

    assert_read_no_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(sdo_oe));
endmodule

// File: rtl/afe_regfile.sv
module afe_regfile
    import afe_ser_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  addr_t                    wr_addr,
    input  word_t                    wr_data,
    input  addr_t                    rd_addr,
    output word_t                    rd_word,
    output word_t                    cfg_q,
    output word_t                    mux_q,
    output logic [NUM_CH*GAIN_W-1:0] gain_o,
    output logic [NUM_CH*OFS_W-1:0]  offset_o
);
    word_t gain_q [NUM_CH];
    word_t ofs_q  [NUM_CH];
    logic  any_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            mux_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_CFG)) cfg_q <= wr_data & CFG_KEEP;
            if (wr_addr == ADDR_W'(ADDR_MUX)) mux_q <= wr_data & MUX_KEEP;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gain_q[ch] <= '0;
                ofs_q[ch]  <= '0;
            end else if (wr_en) begin
                if (wr_addr == ADDR_W'(GAIN_BASE + ch)) gain_q[ch] <= wr_data & GAIN_KEEP;
                if (wr_addr == ADDR_W'(OFS_BASE + ch))  ofs_q[ch]  <= wr_data & OFS_KEEP;
            end
        end
        assign gain_o[ch*GAIN_W +: GAIN_W] = gain_q[ch][GAIN_W-1:0];
        assign offset_o[ch*OFS_W +: OFS_W] = ofs_q[ch];

        assert_gain_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
            gain_q[ch][DATA_W-1:GAIN_W] == '0);

        assert_unmapped_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr > ADDR_W'(LAST_ADDR)) |=> ($stable(gain_q[ch]) && $stable(ofs_q[ch])));
    end

    always_comb begin
        rd_word = '0;
        if (rd_addr == ADDR_W'(ADDR_CFG)) rd_word = cfg_q;
        if (rd_addr == ADDR_W'(ADDR_MUX)) rd_word = mux_q;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (rd_addr == ADDR_W'(GAIN_BASE + ch)) rd_word = gain_q[ch];
            if (rd_addr == ADDR_W'(OFS_BASE + ch))  rd_word = ofs_q[ch];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     any_wr <= 1'b0;
        else if (wr_en) any_wr <= 1'b1;
    end

    assert_ctrl_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[8:6] == 3'b000) && (mux_q[8:5] == 4'b0000));

    assert_unmapped_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > ADDR_W'(LAST_ADDR)) |=> ($stable(cfg_q) && $stable(mux_q)));

    assert_sleep_at_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |-> (cfg_q == '0 && mux_q == '0));
endmodule

// File: rtl/afe_serial_regs.sv
module afe_serial_regs
    import afe_ser_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk,
    input  logic                     frame_n,
    input  logic                     sdi,
    output logic                     sdo,
    output logic                     sdo_oe,
    output logic                     cfg_ext_ref,
    output logic                     cfg_one_byte,
    output logic                     cfg_sha_mode,
    output logic                     cfg_wide_range,
    output logic                     cfg_slow,
    output logic                     cfg_power_on,
    output logic                     mux_reverse,
    output logic [NUM_CH-1:0]        mux_chan_en,
    output logic [NUM_CH*GAIN_W-1:0] gain_o,
    output logic [NUM_CH*OFS_W-1:0]  offset_o
);
    logic [2:0] pins_s;
    addr_t      rd_addr, wr_addr;
    word_t      rd_word, wr_data, cfg_q, mux_q;
    logic       wr_en;

    afe_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, frame_n, sdi}),
        .q     (pins_s)
    );

    afe_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[2]),
        .frame_n_s (pins_s[1]),
        .sdi_s     (pins_s[0]),
        .rd_word   (rd_word),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    afe_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_word  (rd_word),
        .cfg_q    (cfg_q),
        .mux_q    (mux_q),
        .gain_o   (gain_o),
        .offset_o (offset_o)
    );

    assign cfg_ext_ref    = cfg_q[5];
    assign cfg_one_byte   = cfg_q[4];
    assign cfg_sha_mode   = cfg_q[3];
    assign cfg_wide_range = cfg_q[2];
    assign cfg_slow       = cfg_q[1];
    assign cfg_power_on   = cfg_q[0];
    assign mux_reverse    = mux_q[4];
    assign mux_chan_en    = mux_q[NUM_CH-1:0];
endmodule

// File: tb/sim_afe_serial_regs.sv
module sim_afe_serial_regs;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, frame_n = 1'b1, sdi = 1'b0;
    logic sdo, sdo_oe;
    logic cfg_ext_ref, cfg_one_byte, cfg_sha_mode, cfg_wide_range, cfg_slow, cfg_power_on;
    logic mux_reverse;
    logic [3:0]  mux_chan_en;
    logic [23:0] gain_o;
    logic [35:0] offset_o;

    int n_chk = 0, n_fail = 0;
    logic [8:0] model [10];
    logic [8:0] exp_q [$];
    string      tag_q [$];
    logic [8:0] rd_got;
    event       rd_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    afe_serial_regs u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .frame_n(frame_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe),
        .cfg_ext_ref(cfg_ext_ref), .cfg_one_byte(cfg_one_byte), .cfg_sha_mode(cfg_sha_mode),
        .cfg_wide_range(cfg_wide_range), .cfg_slow(cfg_slow), .cfg_power_on(cfg_power_on),
        .mux_reverse(mux_reverse), .mux_chan_en(mux_chan_en),
        .gain_o(gain_o), .offset_o(offset_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [35:0] got, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [8:0] keep_mask(input int a);
        if (a == 0) return 9'h03F;
        if (a == 1) return 9'h01F;
        if (a >= 2 && a <= 5) return 9'h03F;
        return 9'h1FF;
    endfunction

    // Sends one frame of nbits rising edges; captures read data before rises 6..14.
    task automatic send(input int nbits, input logic rw, input logic [3:0] a,
                        input logic [8:0] d, output logic [8:0] got);
        logic [13:0] w;
        w = {rw, a, d};
        got = '0;
        @(negedge clk) frame_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 14) ? w[13-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (rw && i >= 5 && i < 14) begin
                got[13-i] = sdo;
                chk(sdo_oe == 1'b1, "R6 oe during data", 36'(sdo_oe), 36'd1);
            end
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        frame_n = 1'b1;
        repeat (HALF) @(negedge clk);
        chk(sdo_oe == 1'b0, "R6 oe after frame", 36'(sdo_oe), 36'd0);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [8:0] d);
        logic [8:0] g;
        send(14, 1'b0, a, d, g);
        if (a < 10) model[a] = d & keep_mask(a);
    endtask

    task automatic do_read(input logic [3:0] a, input string tag, input logic [8:0] dummy = 9'h000);
        logic [8:0] g;
        exp_q.push_back((a < 10) ? model[a] : 9'h000);
        tag_q.push_back(tag);
        send(14, 1'b1, a, dummy, g);
        rd_got = g;
        ->rd_ev;
        @(negedge clk);
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 10; a++) do_read(4'(a), tag);
    endtask

    task automatic check_outputs();
        chk(cfg_ext_ref == model[0][5], "R8 ext ref", 36'(cfg_ext_ref), 36'(model[0][5]));
        chk(cfg_one_byte == model[0][4], "R8 one byte", 36'(cfg_one_byte), 36'(model[0][4]));
        chk(cfg_sha_mode == model[0][3], "R8 sha mode", 36'(cfg_sha_mode), 36'(model[0][3]));
        chk(cfg_wide_range == model[0][2], "R8 range", 36'(cfg_wide_range), 36'(model[0][2]));
        chk(cfg_slow == model[0][1], "R8 slow", 36'(cfg_slow), 36'(model[0][1]));
        chk(cfg_power_on == model[0][0], "R8 power", 36'(cfg_power_on), 36'(model[0][0]));
        chk(mux_reverse == model[1][4], "R9 reverse", 36'(mux_reverse), 36'(model[1][4]));
        chk(mux_chan_en == model[1][3:0], "R9 chan en", 36'(mux_chan_en), 36'(model[1][3:0]));
        for (int c = 0; c < 4; c++) begin
            chk(gain_o[c*6 +: 6] == model[2+c][5:0], "R3 gain slice",
                36'(gain_o[c*6 +: 6]), 36'(model[2+c][5:0]));
            chk(offset_o[c*9 +: 9] == model[6+c], "R3 offset slice",
                36'(offset_o[c*9 +: 9]), 36'(model[6+c]));
        end
    endtask

    // Monitor: pops the expected read word when a read frame completes.
    initial begin
        forever begin
            @(rd_ev);
            chk(rd_got == exp_q[0], tag_q[0], 36'(rd_got), 36'(exp_q[0]));
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 10; a++) model[a] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R7: reset state, device asleep with all fields zero
        chk(sdo_oe == 1'b0, "R7 oe at reset", 36'(sdo_oe), 36'd0);
        check_outputs();
        read_all("R7 reset readback");

        // R1 R3 R4: full writes, reserved bits dropped, asymmetric patterns
        do_write(4'd0, 9'h1FF);
        do_write(4'd1, 9'h1FF);
        do_write(4'd2, 9'h1C5);
        do_write(4'd3, 9'h03A);
        do_write(4'd4, 9'h12A);
        do_write(4'd5, 9'h03F);
        do_write(4'd6, 9'h1A5);
        do_write(4'd7, 9'h0FF);
        do_write(4'd8, 9'h100);
        do_write(4'd9, 9'h155);
        check_outputs();
        read_all("R1 R4 readback");

        // R8 R9: distinct field patterns
        do_write(4'd0, 9'h015);
        do_write(4'd1, 9'h008);
        check_outputs();
        do_write(4'd0, 9'h02A);
        do_write(4'd1, 9'h011);
        check_outputs();
        do_read(4'd0, "R8 cfg readback");
        do_read(4'd1, "R9 mux readback");

        // R5: unmapped addresses
        do_write(4'd10, 9'h1FF);
        do_write(4'd15, 9'h1FF);
        check_outputs();
        read_all("R5 after unmapped write");
        do_read(4'd10, "R5 unmapped read");
        do_read(4'd15, "R5 unmapped read");

        // R2: short and long write frames are dropped
        begin
            logic [8:0] g;
            send(13, 1'b0, 4'd2, 9'h011, g);
            send(15, 1'b0, 4'd6, 9'h011, g);
            send(13, 1'b0, 4'd0, 9'h001, g);
        end
        check_outputs();
        do_read(4'd2, "R2 short frame dropped");
        do_read(4'd6, "R2 long frame dropped");
        do_read(4'd0, "R2 short cfg dropped");

        // R11: read frame with nonzero data bits leaves contents alone
        do_read(4'd7, "R11 read with data", 9'h1FF);
        do_read(4'd7, "R11 contents intact");
        check_outputs();

        // R10: sleep keeps the rest of the file
        do_write(4'd0, 9'h001);
        check_outputs();
        do_write(4'd0, 9'h000);
        chk(cfg_power_on == 1'b0, "R10 asleep", 36'(cfg_power_on), 36'd0);
        check_outputs();
        read_all("R10 retained in sleep");

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R6 scoreboard drained", 36'(exp_q.size()), 36'd0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule